// File: doc/BRIEF.md
# Per-State Field Microprogrammed Controller

This block is a synchronous control unit. It keeps its state as a one-hot phase vector, and it has a bank of output flip-flops that are set and cleared on request. Its combinational part is not one large lookup table addressed by the state and all inputs together. It is a group of small constant lookup fields, one field for each state. The one-hot phase bit of a state enables that state's field. The field is addressed only by the inputs that its state's conditions read, and it drives only the request lines that can be active in that state.

The data bits of the enabled field are merged by OR onto shared lines. These lines are a set request for each output, a clear request for each output, and one next-phase line for each state. At the clock edge the shared lines update the output flip-flops and the phase vector. A field that is disabled contributes nothing. Any request line that a state's field does not drive stays at 0 in that state, whatever the inputs are.

The default configuration has 6 inputs, 4 outputs and 3 states. Inputs X1..X6 are `x_i[0]..x_i[5]`. Output Zi is `z_o[i-1]`. State k is `phase_o[k-1]`.

Top module: `uctl_fielded`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets `phase_o` to 3'b001, meaning state 1 is active, and sets `z_o` to 0.
- R2: Exactly one bit of `phase_o` is high in every cycle after reset.
- R3: In state 2, inputs X2, X4 and X6 have no effect on the next phase or on the outputs. Only X1, X3 and X5 form that field's address, with X1 as the MSB and X5 as the LSB.
- R4: The state 2 field works as follows, using the 3-bit address {X1,X3,X5}:
  - "Clear Z1" is active at addresses 0, 1, 2, 3 and 5.
  - "Set Z3", "clear Z4" and "go to state 3" are active at addresses 1 and 5.
  - "Go to state 1" is active at addresses 3 and 7.
- R5: The state 1 field works as follows:
  - It sets Z1 on X2&X6 and sets Z2 on X1.
  - It clears Z2 on !X1&X5&X6.
  - It sets Z3 on (X1&!X3)|(X3&X5).
  - It sets Z4 on X5&!X6 and clears Z4 on X3&!X5&X6.
  - It goes to state 2 on X2&X6&!X3 and to state 3 on X3&X5.
- R6: The state 3 field works as follows:
  - It sets Z1 and Z4 on X2&!X6.
  - It clears Z3 on !X2&X6.
  - It goes to state 2 on X2&X6.
- R7: At a clock edge, the phase loads the asserted next-phase line if any next-phase line is high. Otherwise the phase holds.
- R8: At a clock edge, each output goes to 1 on its set request and to 0 on its clear request. It holds when neither request is active.
- R9: Request lines that the active state's field does not drive stay at 0. For example, Z2 never changes in states 2 and 3, and Z1 is never set in state 2.
- R10: The set and clear requests of the same output are never active in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| x_i | input | 6 | Condition inputs; bit 0 is X1, bit 5 is X6 |
| phase_o | output | 3 | One-hot phase; bit k-1 is state k |
| z_o | output | 4 | Output flip-flops; bit i-1 is Zi |

## Verification
The bench steers the controller through every phase transition and then through a long run of random inputs. It compares phase and outputs against a behavioural model on every cycle. In state 2 it toggles X2, X4 and X6 while the field address stays fixed. A field that was addressed by the wrong inputs, or a disabled field that leaked onto the shared lines, would then change an output or the phase.

A wrong content bit shows up as a wrong output on the state where it lives. Examples are a "go to state 1" at address 5 instead of 7, or a swapped address bit order. A phase register that cleared itself when no next-phase line was high would fail the one-hot check. A request line leaking from another state would change Z2 in states 2 or 3.

// File: rtl/uctl_pkg.sv
package uctl_pkg;
   parameter int NUM_IN   = 6;
   parameter int NUM_OUT  = 4;
   parameter int NUM_ST   = 3;
   parameter int NUM_LINE = 2 * NUM_OUT + NUM_ST;
   parameter int ROM_MAX  = 256;

   // shared line numbering: set Zi -> i-1, clear Zi -> NUM_OUT+i-1, go state k -> 2*NUM_OUT+k-1
   function automatic int fld_aw(input int st);
      case (st)
         0: return 5;
         1: return 3;
         default: return 2;
      endcase
   endfunction

   function automatic int fld_dw(input int st);
      case (st)
         0: return 8;
         1: return 5;
         default: return 4;
      endcase
   endfunction

   // input index (0 = X1) feeding address bit b (b = 0 is LSB)
   function automatic int adr_src(input int st, input int b);
      case (st)
         0: case (b) 0: return 5; 1: return 4; 2: return 2; 3: return 1; default: return 0; endcase
         1: case (b) 0: return 4; 1: return 2; default: return 0; endcase
         default: case (b) 0: return 5; default: return 1; endcase
      endcase
   endfunction

   // shared line driven by data bit d
   function automatic int line_dst(input int st, input int d);
      case (st)
         0: case (d)
               0: return 0;  1: return 1;  2: return 5;  3: return 2;
               4: return 3;  5: return 7;  6: return 9;  default: return 10;
            endcase
         1: case (d)
               0: return 4;  1: return 2;  2: return 7;  3: return 10; default: return 8;
            endcase
         default: case (d)
               0: return 0;  1: return 6;  2: return 3;  default: return 9;
            endcase
      endcase
   endfunction

   function automatic bit fld_bit(input int st, input int a, input int d);
      bit p, q, r, s, t;
      case (st)
         0: begin
            // a = {X1,X2,X3,X5,X6}
            p = a[4]; q = a[3]; r = a[2]; s = a[1]; t = a[0];
            case (d)
               0: return q & t;
               1: return p;
               2: return !p & s & t;
               3: return (p & !r) | (r & s);
               4: return s & !t;
               5: return r & !s & t;
               6: return q & t & !r;
               default: return r & s;
            endcase
         end
         1: begin
            // a = {X1,X3,X5}
            case (d)
               0: return (a <= 3) || (a == 5);
               1, 2, 3: return (a == 1) || (a == 5);
               default: return (a == 3) || (a == 7);
            endcase
         end
         default: begin
            // a = {X2,X6}
            q = a[1]; t = a[0];
            case (d)
               0, 2: return q & !t;
               1: return !q & t;
               default: return q & t;
            endcase
         end
      endcase
   endfunction

   function automatic logic [ROM_MAX-1:0] build_rom(input int st);
      logic [ROM_MAX-1:0] r;
      r = '0;
      for (int a = 0; a < (1 << fld_aw(st)); a++)
         for (int d = 0; d < fld_dw(st); d++)
            r[a * fld_dw(st) + d] = fld_bit(st, a, d);
      return r;
   endfunction
endpackage

// File: rtl/uctl_field.sv
module uctl_field #(
   parameter int ST     = 0,
   parameter int N_IN   = uctl_pkg::NUM_IN,
   parameter int N_LINE = uctl_pkg::NUM_LINE
) (
   input  logic              en_i,
   input  logic [N_IN-1:0]   x_i,
   output logic [N_LINE-1:0] lines_o
);
   localparam int AW    = uctl_pkg::fld_aw(ST);
   localparam int DW    = uctl_pkg::fld_dw(ST);
   localparam int ROM_W = (1 << AW) * DW;
   localparam logic [uctl_pkg::ROM_MAX-1:0] ROM_FULL = uctl_pkg::build_rom(ST);
   localparam logic [ROM_W-1:0] ROM = ROM_FULL[ROM_W-1:0];

   if (AW > N_IN || DW > N_LINE || ROM_W > uctl_pkg::ROM_MAX) begin : g_bad_shape
      $error("uctl_field: field %0d does not fit the configured widths", ST);
   end

   logic [AW-1:0] adr;
   logic [DW-1:0] dat;
   logic          unused_x;

   for (genvar b = 0; b < AW; b++) begin : g_adr
      assign adr[b] = x_i[uctl_pkg::adr_src(ST, b)];
   end

   assign unused_x = ^x_i;
   assign dat      = en_i ? ROM[int'(adr) * DW +: DW] : '0;

   always_comb begin
      lines_o = '0;
      for (int d = 0; d < DW; d++)
         lines_o[uctl_pkg::line_dst(ST, d)] = dat[d];
   end
endmodule

// File: rtl/uctl_phase.sv
module uctl_phase #(
   parameter int N_ST = uctl_pkg::NUM_ST
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [N_ST-1:0] nxt_i,
   output logic [N_ST-1:0] phase_o
);
   localparam logic [N_ST-1:0] PH_RST = N_ST'(1);

   logic [N_ST-1:0] phase_q;

   always_ff @(posedge clk) begin
      if (rst)             phase_q <= PH_RST;
      else if (|nxt_i)     phase_q <= nxt_i;
   end

   assign phase_o = phase_q;

   AST_PHASE_RESET: assert property (@(posedge clk) rst |=> (phase_q == PH_RST)); // R1
   AST_PHASE_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $past(rst) || !rst |-> ($countones(phase_q) == 1 || $past(rst))); // R2
   AST_PHASE_LOAD: assert property (@(posedge clk) disable iff (rst)
      (|nxt_i) |=> (phase_q == $past(nxt_i))); // R7
   AST_PHASE_HOLD: assert property (@(posedge clk) disable iff (rst)
      !(|nxt_i) |=> $stable(phase_q)); // R7
endmodule

// File: rtl/uctl_outreg.sv
module uctl_outreg #(
   parameter int N_OUT = uctl_pkg::NUM_OUT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_OUT-1:0] set_i,
   input  logic [N_OUT-1:0] clr_i,
   output logic [N_OUT-1:0] z_o
);
   logic [N_OUT-1:0] z_q;

   always_ff @(posedge clk) begin
      if (rst) z_q <= '0;
      else     z_q <= (z_q | set_i) & ~clr_i;
   end

   assign z_o = z_q;

   for (genvar i = 0; i < N_OUT; i++) begin : g_chk
      AST_Z_SET: assert property (@(posedge clk) disable iff (rst)
         (set_i[i] && !clr_i[i]) |=> z_q[i]); // R8
      AST_Z_CLR: assert property (@(posedge clk) disable iff (rst)
         clr_i[i] |=> !z_q[i]); // R8
      AST_Z_HOLD: assert property (@(posedge clk) disable iff (rst)
         (!set_i[i] && !clr_i[i]) |=> $stable(z_q[i])); // R8
   end
   AST_Z_RESET: assert property (@(posedge clk) rst |=> (z_q == '0)); // R1
endmodule

// File: rtl/uctl_fielded.sv
module uctl_fielded #(
   parameter int N_IN  = uctl_pkg::NUM_IN,
   parameter int N_OUT = uctl_pkg::NUM_OUT,
   parameter int N_ST  = uctl_pkg::NUM_ST
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [N_IN-1:0]  x_i,
   output logic [N_ST-1:0]  phase_o,
   output logic [N_OUT-1:0] z_o
);
   localparam int N_LINE = 2 * N_OUT + N_ST;

   if (N_IN != uctl_pkg::NUM_IN || N_OUT != uctl_pkg::NUM_OUT ||
       N_ST != uctl_pkg::NUM_ST || N_ST < 2) begin : g_bad_cfg
      $error("uctl_fielded: parameters must match the field contents");
   end

   logic [N_LINE-1:0] fld_lines [N_ST];
   logic [N_LINE-1:0] lines;
   logic [N_OUT-1:0]  set_req, clr_req;
   logic [N_ST-1:0]   nxt;
   logic [N_ST-1:0]   phase;

   for (genvar k = 0; k < N_ST; k++) begin : g_fld
      uctl_field #(.ST(k), .N_IN(N_IN), .N_LINE(N_LINE)) fld_i (
         .en_i    (phase[k]),
         .x_i     (x_i),
         .lines_o (fld_lines[k])
      );
   end

   always_comb begin
      lines = '0;
      for (int k = 0; k < N_ST; k++) lines = lines | fld_lines[k];
   end

   assign set_req = lines[N_OUT-1:0];
   assign clr_req = lines[2*N_OUT-1:N_OUT];
   assign nxt     = lines[N_LINE-1:2*N_OUT];

   uctl_phase #(.N_ST(N_ST)) phase_i (
      .clk (clk), .rst (rst), .nxt_i (nxt), .phase_o (phase)
   );

   uctl_outreg #(.N_OUT(N_OUT)) out_i (
      .clk (clk), .rst (rst), .set_i (set_req), .clr_i (clr_req), .z_o (z_o)
   );

   assign phase_o = phase;

   AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
      ((set_req & clr_req) == '0)); // R10
   AST_NEXT_ONEHOT: assert property (@(posedge clk) disable iff (rst)
      $onehot0(nxt)); // R2
   AST_Z2_QUIET: assert property (@(posedge clk) disable iff (rst)
      !phase[0] |-> (!set_req[1] && !clr_req[1])); // R9
endmodule

// File: tb/uctl_fielded_tb.sv
module uctl_fielded_tb_top;
   logic       clk = 1'b0;
   logic       rst;
   logic [5:0] x_r;
   logic [2:0] phase_o;
   logic [3:0] z_o;

   int tests = 0;
   int fails = 0;
   bit done  = 1'b0;

   int         st;
   logic [3:0] zm;

   always #5 clk = ~clk;

   uctl_fielded dut_i (.clk(clk), .rst(rst), .x_i(x_r), .phase_o(phase_o), .z_o(z_o));

   task automatic check(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic model_req(input int s, input logic [5:0] x,
                            output logic [3:0] sr, output logic [3:0] cr, output int go);
      logic x1, x2, x3, x5, x6;
      int a;
      x1 = x[0]; x2 = x[1]; x3 = x[2]; x5 = x[4]; x6 = x[5];
      a  = {29'd0, x1, x3, x5};
      sr = '0; cr = '0; go = 0;
      case (s)
         1: begin // R5
            sr[0] = x2 & x6;
            sr[1] = x1;
            cr[1] = !x1 & x5 & x6;
            sr[2] = (x1 & !x3) | (x3 & x5);
            sr[3] = x5 & !x6;
            cr[3] = x3 & !x5 & x6;
            if (x2 & x6 & !x3) go = 2;
            else if (x3 & x5)  go = 3;
         end
         2: begin // R4
            cr[0] = a inside {0, 1, 2, 3, 5};
            sr[2] = a inside {1, 5};
            cr[3] = a inside {1, 5};
            if (a inside {1, 5})      go = 3;
            else if (a inside {3, 7}) go = 1;
         end
         default: begin // R6
            sr[0] = x2 & !x6;
            sr[3] = x2 & !x6;
            cr[2] = !x2 & x6;
            if (x2 & x6) go = 2;
         end
      endcase
   endtask

   task automatic step(input logic [5:0] xv, input string tag);
      logic [3:0] sr, cr;
      int go;
      string t;
      x_r = xv;
      model_req(st, xv, sr, cr, go);
      t = (tag != "") ? tag : (st == 1) ? "R5" : (st == 2) ? "R4" : "R6";
      check((sr & cr) == 4'd0, "R10", {4'd0, sr & cr}, 8'd0);
      zm = (zm | sr) & ~cr;
      if (go != 0) st = go;
      @(negedge clk);
      check($countones(phase_o) == 1, "R2", {5'd0, phase_o}, 8'd1);
      check(phase_o == 3'(1 << (st - 1)), {"R7/", t}, {5'd0, phase_o}, 8'(1 << (st - 1)));
      check(z_o == zm, {"R8/R9/", t}, {4'd0, z_o}, {4'd0, zm});
   endtask

   initial begin
      rst = 1'b1; x_r = 6'b111111;
      repeat (2) @(negedge clk);
      check(phase_o == 3'b001, "R1", {5'd0, phase_o}, 8'd1);
      check(z_o == 4'd0, "R1", {4'd0, z_o}, 8'd0);
      st = 1; zm = '0;
      rst = 1'b0;
      // state 1 -> 2 with Z1 set
      step(6'b100010, "R5");
      // state 2, address 000: clear Z1, stay
      step(6'b000000, "R4");
      // R3: toggle X2, X4, X6 while {X1,X3,X5} stays 000
      step(6'b101010, "R3");
      step(6'b001000, "R3");
      step(6'b100010, "R3");
      // R9: address 100 in state 2 drives nothing
      step(6'b000001, "R9");
      step(6'b101011, "R3");
      // address 001: clear Z1, set Z3, clear Z4, go to state 3
      step(6'b010000, "R4");
      // state 3: set Z1 and Z4
      step(6'b000010, "R6");
      // state 3: clear Z3
      step(6'b100000, "R6");
      // state 3: nothing asserted, hold (R7)
      step(6'b011101, "R7");
      // state 3 -> 2
      step(6'b100010, "R6");
      // address 011: clear Z1, go to state 1
      step(6'b010100, "R4");
      // address 111 reached from state 2 again
      step(6'b100010, "R5");
      step(6'b010101, "R4");
      for (int i = 0; i < 4000; i++) step(6'($urandom & 32'h3f), "");
      rst = 1'b1;
      @(negedge clk);
      check(phase_o == 3'b001, "R1", {5'd0, phase_o}, 8'd1);
      check(z_o == 4'd0, "R1", {4'd0, z_o}, 8'd0);
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL R7: watchdog expired, actual running expected finished");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end
endmodule